// File: doc/BRIEF.md
# Eight-Slot TDM Audio Serial Transmitter

This block turns up to eight parallel audio channel words into one time-division multiplexed serial line, paired with a frame-sync output. A frame spans 256 bit periods and is split into eight slots of 32 bit periods each. The bit clock itself is produced elsewhere. The block sees it only as `bitEn`, a single-cycle qualifier on the system clock. Each qualified cycle moves the line forward by one bit position.

At the start of every frame, the block captures all eight channel words together with the channel-count mode and the word-width selection. It then pulses `sampleReady` so the producer can present the next frame's words. The frame-sync pulse occupies the last bit period of a frame. Slot 0 begins one bit period later, with its most significant bit first, as in I2S-style one-bit-delayed framing. In four-channel operation only the first four slots carry audio. Bits beyond the active word width are sent as zero, and so are the unused slots.

Top module: `tdm8_tx`

## Requirements
- R1: The frame is 256 bit periods long. `frameSync` is high for exactly one bit period per frame, at position 255.
- R2: The most significant bit of slot 0 appears in the bit period that directly follows the `frameSync` period. The data line is zero while `frameSync` is high.
- R3: Slot k (k = 0..7) occupies positions 32k..32k+31 and carries channel k, taken from `samplesIn[24k+23 : 24k]`. It is sent most significant bit first, starting at bit 24k+23.
- R4: `wordSel` sets the word width: 2'b00 and 2'b11 give 24 bits, 2'b01 gives 20 bits, 2'b10 gives 16 bits. The word sent is the upper part of the 24-bit channel field. Slot positions at or beyond the width are driven as zero.
- R5: With `eightCh` = 0, slots 4 to 7 are driven as zero in every bit position. With `eightCh` = 1, all eight slots carry data.
- R6: Channel words, `eightCh` and `wordSel` are all captured on the qualified cycle that ends the `frameSync` period. Changing them while a frame is being sent does not affect that frame.
- R7: `sampleReady` is high for exactly one clock cycle, in the cycle directly after each capture.
- R8: `frameSync` and `serialOut` change only on clock edges where `bitEn` is high.
- R9: During and right after reset, `frameSync`, `serialOut` and `sampleReady` are 0. The first qualified cycle gives the `frameSync` period, and the second captures the inputs and starts slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle qualifier: advance one bit position |
| eightCh | input | 1 | 1 = eight active channels, 0 = four |
| wordSel | input | 2 | Word width select (see R4) |
| samplesIn | input | 192 | Eight 24-bit channel words, channel k at bits 24k+23:24k |
| frameSync | output | 1 | Frame-sync pulse, one bit period wide |
| serialOut | output | 1 | TDM serial data, MSB first |
| sampleReady | output | 1 | One-cycle request for the next frame's words |

## Verification
The capture of a new frame and the request for the following one fall in the same cycle as a live change of the inputs. The bench rewrites the channel words, the mode and the width one clock after each `sampleReady`, while the frame just captured is still being shifted out. Every bit of that frame is then compared against the values captured before the rewrite. This separates correct frame-boundary capture from continuous sampling. The bench also checks that the first bit after each sync pulse is the new frame's slot-0 MSB.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOTS      = 8;
  localparam int SLOT_CLKS  = 32;
  localparam int MAX_W      = 24;
  localparam int MID_W      = 20;
  localparam int MIN_W      = 16;
  localparam int FRAME_CLKS = SLOTS * SLOT_CLKS;
  localparam int POS_W      = $clog2(FRAME_CLKS);
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int BIT_W      = $clog2(SLOT_CLKS);
  localparam int LANES_W    = SLOTS * MAX_W;

  typedef enum logic [1:0] {
    WID_FULL  = 2'b00,
    WID_MID   = 2'b01,
    WID_SHORT = 2'b10,
    WID_ALT   = 2'b11
  } wordSel_e;

  typedef struct packed {
    logic              capture;
    logic              syncNow;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitIdx;
  } txCtrl_t;

  function automatic logic [BIT_W:0] widthOf(input wordSel_e sel);
    case (sel)
      WID_MID:   widthOf = (BIT_W+1)'(MID_W);
      WID_SHORT: widthOf = (BIT_W+1)'(MIN_W);
      default:   widthOf = (BIT_W+1)'(MAX_W);
    endcase
  endfunction
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  output txCtrl_t ctrl,
  output logic    readyPulse
);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_CLKS - 1);
  localparam logic [POS_W-1:0] RESET_POS = POS_W'(FRAME_CLKS - 2);

  logic [POS_W-1:0] pos;
  logic             lastPos;

  assign lastPos = (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= RESET_POS;
    end else if (bitEn) begin
      pos <= lastPos ? '0 : pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyPulse <= 1'b0;
    end else begin
      readyPulse <= bitEn & lastPos;
    end
  end

  always_comb begin
    ctrl.capture = bitEn & lastPos;
    ctrl.syncNow = lastPos;
    ctrl.slot    = pos[POS_W-1 -: SLOT_W];
    ctrl.bitIdx  = pos[BIT_W-1:0];
  end
endmodule

// File: rtl/tdm_tx_data.sv
module tdm_tx_data
  import tdm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  txCtrl_t            ctrl,
  input  logic [LANES_W-1:0] samplesIn,
  input  logic               eightCh,
  input  logic [1:0]         wordSel,
  output logic               serialOut
);
  logic [MAX_W-1:0] shadow [SLOTS];
  logic             cfgEight;
  wordSel_e         cfgWidth;

  genvar ch;
  generate
    for (ch = 0; ch < SLOTS; ch++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadow[ch] <= '0;
        end else if (ctrl.capture) begin
          shadow[ch] <= samplesIn[ch*MAX_W +: MAX_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEight <= 1'b1;
      cfgWidth <= WID_FULL;
    end else if (ctrl.capture) begin
      cfgEight <= eightCh;
      cfgWidth <= wordSel_e'(wordSel);
    end
  end

  logic [MAX_W-1:0] chWord;
  logic [MAX_W-1:0] shifted;
  logic [BIT_W:0]   activeW;
  logic             inWord;
  logic             slotUsed;

  always_comb begin
    chWord   = shadow[ctrl.slot];
    shifted  = chWord << ctrl.bitIdx;
    activeW  = widthOf(cfgWidth);
    inWord   = ({1'b0, ctrl.bitIdx} < activeW);
    slotUsed = cfgEight || (ctrl.slot < SLOT_W'(SLOTS / 2));
    serialOut = inWord && slotUsed && !ctrl.syncNow && shifted[MAX_W-1];
  end
endmodule

// File: rtl/tdm8_tx.sv
module tdm8_tx
  import tdm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitEn,
  input  logic               eightCh,
  input  logic [1:0]         wordSel,
  input  logic [LANES_W-1:0] samplesIn,
  output logic               frameSync,
  output logic               serialOut,
  output logic               sampleReady
);
  txCtrl_t ctrlBus;

  tdm_tx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .ctrl       (ctrlBus),
    .readyPulse (sampleReady)
  );

  tdm_tx_data u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlBus),
    .samplesIn (samplesIn),
    .eightCh   (eightCh),
    .wordSel   (wordSel),
    .serialOut (serialOut)
  );

  assign frameSync = ctrlBus.syncNow;
endmodule

// File: rtl/tdm8_tx_chk.sv
module tdm8_tx_chk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic frameSync,
  input logic serialOut,
  input logic sampleReady
);
  // R1
  sync_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && bitEn) |=> !frameSync);

  // R2
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> !serialOut);

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |=> !sampleReady);

  // R7
  ready_after_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameSync) |-> sampleReady);

  // R7
  ready_only_at_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> $fell(frameSync));

  // R8
  hold_between_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(serialOut) && $stable(frameSync)));
endmodule

bind tdm8_tx tdm8_tx_chk u_chk (.*);

// File: tb/tdm8_tx_bench.sv
`timescale 1ns/1ps
module tdm8_tx_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bitEn = 1'b0;
  logic         eightCh = 1'b1;
  logic [1:0]   wordSel = 2'b00;
  logic [191:0] samplesIn = '0;
  logic         frameSync, serialOut, sampleReady;

  tdm8_tx u_tdm8_tx (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .eightCh(eightCh),
    .wordSel(wordSel), .samplesIn(samplesIn),
    .frameSync(frameSync), .serialOut(serialOut), .sampleReady(sampleReady)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic  fs;
    logic  sd;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  localparam int NFRAMES = 8;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int widthFor(input logic [1:0] w);
    case (w)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

  // R3 R4 R5: expected line value at one frame position
  task automatic pushFrame(input logic [191:0] s, input logic e, input logic [1:0] w);
    for (int pos = 0; pos < 256; pos++) begin
      expItem_t it;
      int slot = pos / 32;
      int b = pos % 32;
      it.fs = (pos == 255);
      if (pos == 255) begin
        it.sd = 1'b0; it.tag = "R1";
      end else if (!e && slot >= 4) begin
        it.sd = 1'b0; it.tag = "R5";
      end else if (b >= widthFor(w)) begin
        it.sd = 1'b0; it.tag = "R4";
      end else begin
        it.sd = s[slot*24 + 23 - b];
        it.tag = (pos == 0) ? "R2" : "R3/R6";
      end
      expQ.push_back(it);
    end
  endtask

  function automatic logic [191:0] patternFor(input int f);
    logic [191:0] s;
    for (int ch = 0; ch < 8; ch++) begin
      if (f >= 6) s[ch*24 +: 24] = 24'hFFFFFF;
      else s[ch*24 +: 24] = (24'h9A3C5 * 24'(f + 1)) ^ (24'h111111 * 24'(ch)) ^ 24'h800001;
    end
    return s;
  endfunction

  function automatic logic modeFor(input int f);
    return !(f == 3 || f == 4 || f == 6);
  endfunction

  function automatic logic [1:0] widFor(input int f);
    case (f)
      1: return 2'b01;
      2: return 2'b10;
      4: return 2'b10;
      5: return 2'b11;
      6: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic applyFrame(input int f);
    samplesIn = patternFor(f);
    eightCh   = modeFor(f);
    wordSel   = widFor(f);
    pushFrame(patternFor(f), modeFor(f), widFor(f));
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: drives bit qualifier, pops and compares
  initial begin
    expItem_t it;
    logic fsSeen, sdSeen;
    @(posedge rstN);
    while (!done) begin
      @(negedge clk); bitEn = 1'b1;
      @(negedge clk); bitEn = 1'b0;
      if (done) break;
      fsSeen = frameSync; sdSeen = serialOut;
      if (expQ.size() == 0) begin
        check("R1 queue underflow", 32'd1, 32'd0);
      end else begin
        it = expQ.pop_front();
        check({it.tag, " frameSync"}, {31'b0, fsSeen}, {31'b0, it.fs});
        check({it.tag, " serialOut"}, {31'b0, sdSeen}, {31'b0, it.sd});
      end
      repeat (2) begin
        @(negedge clk);
        // R8: no movement without bitEn
        check("R8 hold", {30'b0, frameSync, serialOut}, {30'b0, fsSeen, sdSeen});
      end
    end
  end

  // driver
  initial begin
    expItem_t pre;
    pre.fs = 1'b1; pre.sd = 1'b0; pre.tag = "R9";
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 frameSync", {31'b0, frameSync}, 32'd0);
    check("R9 serialOut", {31'b0, serialOut}, 32'd0);
    check("R9 sampleReady", {31'b0, sampleReady}, 32'd0);
    expQ.push_back(pre);
    applyFrame(0);
    rstN = 1'b1;
    for (int f = 1; f <= NFRAMES; f++) begin
      while (!sampleReady) @(negedge clk);
      @(negedge clk);
      // R7 single-cycle request
      check("R7 ready width", {31'b0, sampleReady}, 32'd0);
      // R6: inputs rewritten while the captured frame is still going out
      if (f < NFRAMES) applyFrame(f);
      else begin
        samplesIn = '0; eightCh = 1'b0; wordSel = 2'b10;
      end
    end
    while (expQ.size() != 0) @(negedge clk);
    done = 1'b1;
    repeat (8) @(negedge clk);
    finishRun();
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end
endmodule